// File: doc/BRIEF.md
# Two-Level Memory Fill Sequencer

The block writes a computed pattern into a rectangular region of a synchronous single-port memory. The region is described by a base address and two loop bounds: an outer count and an inner count. The sequencer walks an index pair (i, j) in row-major order, with the inner index running fastest. It issues one memory access per clock. The memory array sits outside the block, normally in the testbench or the surrounding chip.

A fill begins when a start pulse arrives while the block is idle. The block signals the end of a fill by raising done. In direct mode every element is written in a single cycle with a value that depends only on its linear position. In update mode each element first reads the word already stored at its address. One cycle later it writes that old word plus the position pattern. The block can be started again as often as needed, including in the same cycle that done is seen.

Top module: `mem2d_fill`

## Requirements
- R1: After reset, done_o is high, and neither mem_we_o nor mem_re_o is asserted until a start is accepted.
- R2: start_i is accepted only while done_o is high. A start pulse during a fill is ignored, and the ongoing write sequence is unchanged.
- R3: The k-th write of a fill (counting from 0) targets base + k, taken modulo 2^AW, so the address wraps past the top of memory.
- R4: Elements are visited in row-major order. j runs from 0 to n_inner-1, then returns to 0 while i advances by one. Element (i, j) has linear position i*n_inner + j.
- R5: In direct mode (rmw_i = 0), one write is issued every cycle. Its data is (i*n_inner + j) XOR SEED, truncated to DW bits. The first write appears in the cycle after the accepting edge. done_o goes high in the cycle after the last write, which is N+1 cycles after acceptance for N elements.
- R6: In update mode (rmw_i = 1), each element uses two cycles. The first cycle is a read at the element address, with data returning one cycle later. The second cycle is a write to the same address of old + ((i*n_inner + j) XOR SEED), modulo 2^DW. A fill takes 2N+1 cycles until done_o.
- R7: If n_outer_i or n_inner_i is zero at start, no read or write is issued. done_o is low for exactly one cycle and is high again two cycles after the accepting edge.
- R8: Base address, both bounds and the mode are captured when start is accepted. Changing these inputs during a fill has no effect on that fill.
- R9: A new fill can be started in the first cycle in which done_o is high, and it behaves exactly like the first fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted while done_o is high |
| rmw_i | input | 1 | 1 selects update mode, 0 selects direct mode |
| base_i | input | AW | First address of the region |
| n_outer_i | input | IW | Outer loop count |
| n_inner_i | input | IW | Inner loop count |
| done_o | output | 1 | High while idle |
| mem_addr_o | output | AW | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | DW | Memory write data |
| mem_re_o | output | 1 | Memory read enable |
| mem_rdata_i | input | DW | Memory read data, one cycle after mem_re_o |

## Verification
The bench targets several corner cases:
- **Inner-to-outer wrap.** A design that advanced i at the wrong inner count would write a shifted pattern.
- **Address wrap past the top of memory.** A counter that saturated or widened would write the wrong words.
- **Update mode.** The read data must be consumed exactly one cycle after the read. A design off by a cycle would add the pattern to stale data.
- **Zero bounds.** A design that entered its loop anyway would issue stray writes.
- **Start and bound changes during a busy fill.** A design that did not capture its inputs would restart the fill or change its shape partway through.
- **Back-to-back restarts.** A design that lost a start on the done cycle would show up as a cycle-count mismatch.

// File: rtl/mem2d_fill_pkg.sv
package mem2d_fill_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EMPTY,
    ST_WRITE,
    ST_READ,
    ST_MODW
  } fill_st_e;
endpackage

// File: rtl/mem2d_fill_idx.sv
module mem2d_fill_idx #(
  parameter int IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [IW-1:0] n_outer_i,
  input  logic [IW-1:0] n_inner_i,
  output logic [IW-1:0] i_o,
  output logic [IW-1:0] j_o,
  output logic          last_o
);
  logic [IW-1:0] i_q, j_q;
  logic          j_end;

  assign j_end  = (j_q == n_inner_i - IW'(1));
  assign last_o = j_end && (i_q == n_outer_i - IW'(1));
  assign i_o    = i_q;
  assign j_o    = j_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_q <= '0;
      j_q <= '0;
    end else if (load_i) begin
      i_q <= '0;
      j_q <= '0;
    end else if (step_i) begin
      if (j_end) begin
        j_q <= '0;
        i_q <= i_q + IW'(1);
      end else begin
        j_q <= j_q + IW'(1);
      end
    end
  end

  // R4
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (j_q < n_inner_i) && (i_q < n_outer_i));
endmodule

// File: rtl/mem2d_fill_pat.sv
module mem2d_fill_pat #(
  parameter int          IW   = 4,
  parameter int          DW   = 16,
  parameter logic [DW-1:0] SEED = '0
) (
  input  logic [IW-1:0] i_i,
  input  logic [IW-1:0] j_i,
  input  logic [IW-1:0] n_inner_i,
  input  logic [DW-1:0] old_i,
  input  logic          rmw_i,
  output logic [DW-1:0] data_o
);
  localparam int LW = 2 * IW + 1;

  logic [LW-1:0] lin;
  logic [DW-1:0] lin_dw;
  logic [DW-1:0] mix;

  assign lin = LW'(i_i) * LW'(n_inner_i) + LW'(j_i);

  generate
    if (DW > LW) begin : g_ext
      assign lin_dw = {{(DW - LW){1'b0}}, lin};
    end else begin : g_trunc
      assign lin_dw = lin[DW-1:0];
    end
  endgenerate

  assign mix    = lin_dw ^ SEED;
  assign data_o = rmw_i ? (old_i + mix) : mix;
endmodule

// File: rtl/mem2d_fill.sv
module mem2d_fill
  import mem2d_fill_pkg::*;
#(
  parameter int            AW   = 8,
  parameter int            DW   = 16,
  parameter int            IW   = 4,
  parameter logic [DW-1:0] SEED = 16'hA5C3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rmw_i,
  input  logic [AW-1:0] base_i,
  input  logic [IW-1:0] n_outer_i,
  input  logic [IW-1:0] n_inner_i,
  output logic          done_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_re_o,
  input  logic [DW-1:0] mem_rdata_i
);
  fill_st_e      state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [IW-1:0] n_out_q, n_in_q;
  logic          rmw_q;
  logic          accept, empty_req, step, last;
  logic [IW-1:0] idx_i, idx_j;

  assign done_o    = (state_q == ST_IDLE);
  assign accept    = done_o && start_i;
  assign empty_req = (n_outer_i == '0) || (n_inner_i == '0);
  assign mem_we_o  = (state_q == ST_WRITE) || (state_q == ST_MODW);
  assign mem_re_o  = (state_q == ST_READ);
  assign step      = mem_we_o;
  assign mem_addr_o = addr_q;

  mem2d_fill_idx #(.IW(IW)) u_idx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .step_i    (step),
    .n_outer_i (n_out_q),
    .n_inner_i (n_in_q),
    .i_o       (idx_i),
    .j_o       (idx_j),
    .last_o    (last)
  );

  mem2d_fill_pat #(.IW(IW), .DW(DW), .SEED(SEED)) u_pat (
    .i_i       (idx_i),
    .j_i       (idx_j),
    .n_inner_i (n_in_q),
    .old_i     (mem_rdata_i),
    .rmw_i     (rmw_q),
    .data_o    (mem_wdata_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = empty_req ? ST_EMPTY : (rmw_i ? ST_READ : ST_WRITE);
      ST_EMPTY: state_d = ST_IDLE;
      ST_WRITE: if (last) state_d = ST_IDLE;
      ST_READ:  state_d = ST_MODW;
      ST_MODW:  state_d = last ? ST_IDLE : ST_READ;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      n_out_q <= '0;
      n_in_q  <= '0;
      rmw_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= base_i;
        n_out_q <= n_outer_i;
        n_in_q  <= n_inner_i;
        rmw_q   <= rmw_i;
      end else if (step) begin
        addr_q <= addr_q + AW'(1);
      end
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !(mem_we_o || mem_re_o) || (mem_addr_o == $past(mem_addr_o) + AW'(1)));

  // R5
  first_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !empty_req && !rmw_i) |=> mem_we_o && (mem_addr_o == $past(base_i)));

  // R6
  rmw_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && rmw_q) |-> $past(mem_re_o) && (mem_addr_o == $past(mem_addr_o)));

  // R7
  empty_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && empty_req) |=> (!mem_we_o && !mem_re_o && !done_o) ##1 done_o);
endmodule

// File: tb/mem2d_fill_bench.sv
module mem2d_fill_bench;
  localparam int            AW   = 8;
  localparam int            DW   = 16;
  localparam int            IW   = 4;
  localparam logic [DW-1:0] SEED = 16'hA5C3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, rmw_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic [IW-1:0] n_outer_i = '0, n_inner_i = '0;
  logic          done_o, mem_we_o, mem_re_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata;

  logic [DW-1:0] mem    [2**AW];
  logic [DW-1:0] shadow [2**AW];
  logic [AW+DW-1:0] exp_q[$];
  int compared = 0, mismatched = 0, n_writes = 0;

  always #5 clk = ~clk;

  mem2d_fill #(.AW(AW), .DW(DW), .IW(IW), .SEED(SEED)) u_mem2d_fill (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .rmw_i(rmw_i),
    .base_i(base_i), .n_outer_i(n_outer_i), .n_inner_i(n_inner_i),
    .done_o(done_o), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
    .mem_wdata_o(mem_wdata_o), .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata));

  always @(posedge clk) begin
    if (mem_re_o) mem_rdata <= mem[mem_addr_o];
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: R3 R4 R5 R6 R8
  always @(negedge clk) begin
    if (rst_n && mem_we_o) begin
      n_writes++;
      if (exp_q.size() == 0) begin
        check("R2 unexpected write", {mem_addr_o, mem_wdata_o}, '1);
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        check("R3 address", 32'(mem_addr_o), 32'(e[AW+DW-1:DW]));
        check("R5 R6 data", 32'(mem_wdata_o), 32'(e[DW-1:0]));
      end
    end
  end

  task automatic run_fill(input logic [AW-1:0] base, input int ni, input int nj,
                          input logic rmw, input bit disturb);
    int cyc, w0, n;
    n = ni * nj;
    for (int i = 0; i < ni; i++) begin
      for (int j = 0; j < nj; j++) begin
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        a = base + AW'(i * nj + j);
        d = DW'(i * nj + j) ^ SEED;
        if (rmw) d = shadow[a] + d;
        shadow[a] = d;
        exp_q.push_back({a, d});
      end
    end
    w0 = n_writes;
    base_i = base; n_outer_i = IW'(ni); n_inner_i = IW'(nj); rmw_i = rmw;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 5000) begin
      if (disturb && cyc == 2) begin
        start_i = 1'b1; base_i = 8'h80; n_inner_i = 4'd7; n_outer_i = 4'd9; rmw_i = ~rmw;
      end
      if (disturb && cyc == 4) start_i = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    if (n == 0) check("R7 cycles to done", cyc, 2);
    else if (rmw) check("R6 cycles to done", cyc, 2 * n + 1);
    else check("R5 cycles to done", cyc, n + 1);
    check("R4 write count", n_writes - w0, n);
    check("R8 queue drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int a = 0; a < 2**AW; a++) begin
      mem[a] = DW'(a * 37 + 5);
      shadow[a] = DW'(a * 37 + 5);
    end
    repeat (3) @(negedge clk);
    // R1
    check("R1 done in reset", done_o, 1'b1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 done after reset", done_o, 1'b1);
    check("R1 no access", {mem_we_o, mem_re_o}, 2'b00);

    run_fill(8'h10, 3, 4, 1'b0, 1'b0);    // R4 R5
    run_fill(8'h10, 3, 4, 1'b1, 1'b0);    // R6
    run_fill(8'hFC, 2, 5, 1'b0, 1'b0);    // R3 wrap
    run_fill(8'h30, 0, 3, 1'b0, 1'b0);    // R7
    run_fill(8'h30, 3, 0, 1'b1, 1'b0);    // R7
    run_fill(8'h40, 4, 3, 1'b0, 1'b1);    // R2 R8
    run_fill(8'h50, 2, 3, 1'b1, 1'b1);    // R2 R8 update mode
    run_fill(8'h00, 15, 15, 1'b0, 1'b0);  // R9 back-to-back
    run_fill(8'h00, 15, 15, 1'b1, 1'b0);  // R9
    run_fill(8'hF0, 1, 1, 1'b1, 1'b0);

    // R9: memory contents follow the model
    for (int a = 0; a < 2**AW; a++) begin
      if (mem[a] !== shadow[a]) check("R9 memory image", 32'(mem[a]), 32'(shadow[a]));
    end
    compared++;
    check("R1 idle at end", done_o, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule